// File: doc/BRIEF.md
# Pipeline Stall and Flush Controller

This block steers an in-order, five-stage pipeline (fetch, decode, execute, memory, writeback) that has no operand forwarding. Each cycle it reads the register operands of the instruction in decode. It compares them against the destinations of older instructions that have not yet committed their result. When a read would see a stale value, it freezes the PC and the fetch/decode register and sends a bubble into execute. The decode instruction then waits until its producer has reached writeback. When the memory stage reports a taken branch or jump, the block selects the redirect target for the PC. It also discards the three younger instructions by clearing the pipeline registers that feed decode, execute and memory.

The controller keeps its own small record of the destination register and write flag for each in-flight slot past decode. It updates that record with the same hold, bubble and squash decisions it sends to the datapath. The datapath therefore only supplies the decode-stage fields and the memory-stage redirect flag. Fetch always falls through to PC+4 unless a redirect arrives. With the default configuration the register file is taken to be write-through, so only the execute and memory slots are compared. Setting `TRACK_WB` adds the writeback slot for a register file that is not write-through.

Top module: `hzd_unit`

## Requirements
- R1: After reset, with no redirect and a decode instruction that reads no register, the block shows the free-running pattern: `pc_sel`=0, `if_en`=1, `id_en`=1 and all three clears 0.
- R2: When a used decode source equals the nonzero destination of a writing instruction in the execute slot, the block stalls. A stall is `if_en`=0, `id_en`=0, `clr_ex`=1, `clr_id`=0, `clr_mem`=0 and `pc_sel`=1 (hold).
- R3: When a used decode source equals the nonzero destination of a writing instruction in the memory slot, the block stalls in the same way.
- R4: With `TRACK_WB`=0, a writer three or more instructions ahead of the reader causes no stall.
- R5: Register index 0 never causes a stall, whether it appears as a destination or as a source.
- R6: A source whose use flag is low never causes a stall, even if its index matches.
- R7: An older instruction whose write flag is low never causes a stall.
- R8: A reader directly behind its producer stalls for exactly 2 cycles. A reader with one unrelated instruction in between stalls for exactly 1 cycle. No stall lasts longer than 2 consecutive cycles.
- R9: When `mem_redirect` is 1, the block flushes: `pc_sel`=2 (redirect target), `if_en`=1, `id_en`=1, and `clr_id`, `clr_ex` and `clr_mem` are all 1.
- R10: A flush overrides a stall that would arise in the same cycle. The outputs are those of R9.
- R11: Instructions squashed by a flush cause no later stall. In the cycle after a redirect, the block does not stall.
- R12: With no hazard and no redirect, `pc_sel`=0 (PC+4), both enables are 1 and no clear is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | REG_AW | First source index of the decode instruction |
| id_rs1_used | input | 1 | The decode instruction reads its first source |
| id_rs2 | input | REG_AW | Second source index of the decode instruction |
| id_rs2_used | input | 1 | The decode instruction reads its second source |
| id_rd | input | REG_AW | Destination index of the decode instruction |
| id_rd_we | input | 1 | The decode instruction writes its destination |
| mem_redirect | input | 1 | Taken branch or jump resolved in the memory stage |
| pc_sel | output | 2 | 0 = PC+4, 1 = hold, 2 = redirect target |
| if_en | output | 1 | Load enable of the PC register |
| id_en | output | 1 | Load enable of the fetch/decode register |
| clr_id | output | 1 | Clear the fetch/decode register |
| clr_ex | output | 1 | Clear the decode/execute register (bubble) |
| clr_mem | output | 1 | Clear the execute/memory register |

## Verification
A stall and a flush can fall in the same cycle. This happens when a reader sits in decode while its producer is in execute and the memory stage reports a taken branch. The bench sets up this case by placing a writer in decode, then presenting a dependent reader together with `mem_redirect` one cycle later. The outputs must show the full flush with no hold. In the following cycle the same reader is presented again and must pass without a stall, because its producer was squashed.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  // PC source selection, encoded as stated in the requirements
  typedef enum logic [1:0] {
    PCS_SEQ   = 2'd0,
    PCS_HOLD  = 2'd1,
    PCS_REDIR = 2'd2
  } pc_sel_e;

  // Control bundle produced by the arbiter
  typedef struct packed {
    pc_sel_e pc_sel;
    logic    if_en;
    logic    id_en;
    logic    clr_id;
    logic    clr_ex;
    logic    clr_mem;
  } hzd_ctl_t;

  localparam int unsigned BASE_SLOTS = 2;

endpackage

// File: rtl/hzd_rst_sync.sv
module hzd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/hzd_dest_track.sv
module hzd_dest_track #(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned NSLOT  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ex_bubble,
  input  logic                          squash_mem,
  input  logic [REG_AW-1:0]             id_rd,
  input  logic                          id_rd_we,
  output logic [NSLOT-1:0][REG_AW-1:0]  slot_rd,
  output logic [NSLOT-1:0]              slot_we
);

  logic [NSLOT-1:0][REG_AW-1:0] rd_d;
  logic [NSLOT-1:0]             we_d;
  logic                         trk_en;

  // The stages past decode never hold, so every slot loads each cycle
  assign trk_en = 1'b1;

  // Slot 0 mirrors the decode/execute register, slot 1 execute/memory, ...
  always_comb begin
    rd_d[0] = id_rd;
    we_d[0] = id_rd_we & ~ex_bubble;
  end

  genvar s;
  generate
    for (s = 1; s < NSLOT; s++) begin : g_shift
      always_comb begin
        rd_d[s] = slot_rd[s-1];
        if (s == 1) begin
          we_d[s] = slot_we[s-1] & ~squash_mem;
        end else begin
          we_d[s] = slot_we[s-1];
        end
      end
    end

    for (s = 0; s < NSLOT; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_rd[s] <= '0;
          slot_we[s] <= 1'b0;
        end else if (trk_en) begin
          slot_rd[s] <= rd_d[s];
          slot_we[s] <= we_d[s];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/hzd_raw_detect.sv
module hzd_raw_detect #(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned NSLOT  = 2
) (
  input  logic [REG_AW-1:0]             rs1,
  input  logic                          rs1_used,
  input  logic [REG_AW-1:0]             rs2,
  input  logic                          rs2_used,
  input  logic [NSLOT-1:0][REG_AW-1:0]  slot_rd,
  input  logic [NSLOT-1:0]              slot_we,
  output logic                          hazard
);

  logic [NSLOT-1:0] hit;

  genvar s;
  generate
    for (s = 0; s < NSLOT; s++) begin : g_cmp
      logic live;
      logic m1;
      logic m2;
      always_comb begin
        live   = slot_we[s] && (slot_rd[s] != '0);
        m1     = rs1_used && (rs1 == slot_rd[s]);
        m2     = rs2_used && (rs2 == slot_rd[s]);
        hit[s] = live && (m1 || m2);
      end
    end
  endgenerate

  assign hazard = |hit;

endmodule

// File: rtl/hzd_ctrl_arb.sv
module hzd_ctrl_arb
  import hzd_pkg::*;
(
  input  logic     hazard,
  input  logic     redirect,
  output hzd_ctl_t ctl,
  output logic     ex_bubble,
  output logic     squash_mem
);

  logic do_stall;

  always_comb begin
    do_stall    = hazard && !redirect;
    ctl.pc_sel  = PCS_SEQ;
    ctl.if_en   = 1'b1;
    ctl.id_en   = 1'b1;
    ctl.clr_id  = 1'b0;
    ctl.clr_ex  = 1'b0;
    ctl.clr_mem = 1'b0;
    if (redirect) begin
      ctl.pc_sel  = PCS_REDIR;
      ctl.clr_id  = 1'b1;
      ctl.clr_ex  = 1'b1;
      ctl.clr_mem = 1'b1;
    end else if (do_stall) begin
      ctl.pc_sel  = PCS_HOLD;
      ctl.if_en   = 1'b0;
      ctl.id_en   = 1'b0;
      ctl.clr_ex  = 1'b1;
    end
    ex_bubble  = ctl.clr_ex;
    squash_mem = ctl.clr_mem;
  end

endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
  import hzd_pkg::*;
#(
  parameter int unsigned REG_AW   = 5,
  parameter bit          TRACK_WB = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic              id_rs1_used,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_rs2_used,
  input  logic [REG_AW-1:0] id_rd,
  input  logic              id_rd_we,
  input  logic              mem_redirect,
  output logic [1:0]        pc_sel,
  output logic              if_en,
  output logic              id_en,
  output logic              clr_id,
  output logic              clr_ex,
  output logic              clr_mem
);

  localparam int unsigned NSLOT = BASE_SLOTS + (TRACK_WB ? 1 : 0);

  logic                         rst_n_int;
  logic [NSLOT-1:0][REG_AW-1:0] slot_rd;
  logic [NSLOT-1:0]             slot_we;
  logic                         hazard;
  logic                         ex_bubble;
  logic                         squash_mem;
  hzd_ctl_t                     ctl;

  hzd_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  hzd_dest_track #(.REG_AW(REG_AW), .NSLOT(NSLOT)) trk_i (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .ex_bubble  (ex_bubble),
    .squash_mem (squash_mem),
    .id_rd      (id_rd),
    .id_rd_we   (id_rd_we),
    .slot_rd    (slot_rd),
    .slot_we    (slot_we)
  );

  hzd_raw_detect #(.REG_AW(REG_AW), .NSLOT(NSLOT)) det_i (
    .rs1      (id_rs1),
    .rs1_used (id_rs1_used),
    .rs2      (id_rs2),
    .rs2_used (id_rs2_used),
    .slot_rd  (slot_rd),
    .slot_we  (slot_we),
    .hazard   (hazard)
  );

  hzd_ctrl_arb arb_i (
    .hazard     (hazard),
    .redirect   (mem_redirect),
    .ctl        (ctl),
    .ex_bubble  (ex_bubble),
    .squash_mem (squash_mem)
  );

  assign pc_sel  = ctl.pc_sel;
  assign if_en   = ctl.if_en;
  assign id_en   = ctl.id_en;
  assign clr_id  = ctl.clr_id;
  assign clr_ex  = ctl.clr_ex;
  assign clr_mem = ctl.clr_mem;

endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk #(
  parameter int unsigned REG_AW   = 5,
  parameter bit          TRACK_WB = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] id_rs1,
  input logic              id_rs1_used,
  input logic              id_rs2_used,
  input logic              mem_redirect,
  input logic [1:0]        pc_sel,
  input logic              if_en,
  input logic              id_en,
  input logic              clr_id,
  input logic              clr_ex,
  input logic              clr_mem
);

  // R9
  flush_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_redirect |-> (pc_sel == 2'd2 && if_en && id_en && clr_id && clr_ex && clr_mem));

  // R2
  stall_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !if_en |-> (!id_en && clr_ex && !clr_id && !clr_mem && pc_sel == 2'd1));

  // R8
  stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_en && $past(!if_en)) |=> if_en);

  // R5
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs1_used && id_rs1 == '0 && !id_rs2_used) |-> if_en);

  // R6
  unused_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_rs1_used && !id_rs2_used) |-> if_en);

  // R12
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_redirect && if_en) |-> (pc_sel == 2'd0 && !clr_id && !clr_ex && !clr_mem));

  generate
    if (!TRACK_WB) begin : g_nowb
      // R11
      post_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_redirect) |-> if_en);
    end
  endgenerate

endmodule

bind hzd_unit hzd_unit_chk #(.REG_AW(REG_AW), .TRACK_WB(TRACK_WB)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .id_rs1       (id_rs1),
  .id_rs1_used  (id_rs1_used),
  .id_rs2_used  (id_rs2_used),
  .mem_redirect (mem_redirect),
  .pc_sel       (pc_sel),
  .if_en        (if_en),
  .id_en        (id_en),
  .clr_id       (clr_id),
  .clr_ex       (clr_ex),
  .clr_mem      (clr_mem)
);

// File: tb/hzd_unit_tb.sv
`timescale 1ns/1ps
module hzd_unit_tb_top;

  localparam int AW = 5;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] id_rs1;
  logic          id_rs1_used;
  logic [AW-1:0] id_rs2;
  logic          id_rs2_used;
  logic [AW-1:0] id_rd;
  logic          id_rd_we;
  logic          mem_redirect;
  logic [1:0]    pc_sel;
  logic          if_en;
  logic          id_en;
  logic          clr_id;
  logic          clr_ex;
  logic          clr_mem;

  int checks;
  int failures;

  hzd_unit #(.REG_AW(AW), .TRACK_WB(1'b0)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .id_rs1       (id_rs1),
    .id_rs1_used  (id_rs1_used),
    .id_rs2       (id_rs2),
    .id_rs2_used  (id_rs2_used),
    .id_rd        (id_rd),
    .id_rd_we     (id_rd_we),
    .mem_redirect (mem_redirect),
    .pc_sel       (pc_sel),
    .if_en        (if_en),
    .id_en        (id_en),
    .clr_id       (clr_id),
    .clr_ex       (clr_ex),
    .clr_mem      (clr_mem)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [6:0] outs();
    return {pc_sel, if_en, id_en, clr_id, clr_ex, clr_mem};
  endfunction

  localparam logic [6:0] PAT_FREE  = 7'b00_1_1_0_0_0;
  localparam logic [6:0] PAT_STALL = 7'b01_0_0_0_1_0;
  localparam logic [6:0] PAT_FLUSH = 7'b10_1_1_1_1_1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_nop();
    id_rs1 = '0; id_rs1_used = 1'b0;
    id_rs2 = '0; id_rs2_used = 1'b0;
    id_rd  = '0; id_rd_we    = 1'b0;
    mem_redirect = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); set_nop();
    end
  endtask

  task automatic run_pair(input logic [AW-1:0] w_rd, input bit w_we, input int d,
                          input logic [AW-1:0] r1, input bit u1,
                          input logic [AW-1:0] r2, input bit u2);
    bit    hz;
    int    exp_st;
    int    st;
    bit    done;
    bit    shape_ok;
    string req;
    hz = w_we && (w_rd != 0) && ((u1 && r1 == w_rd) || (u2 && r2 == w_rd));
    exp_st = (hz && d < 3) ? 3 - d : 0;
    if (w_rd == 0)      req = "R5";
    else if (!w_we)     req = "R7";
    else if (!hz)       req = "R6";
    else if (d == 1)    req = "R2/R8";
    else if (d == 2)    req = "R3/R8";
    else                req = "R4";
    drain();
    @(negedge clk); set_nop(); id_rd = w_rd; id_rd_we = w_we;
    #2;
    // R12: writer with nothing ahead passes freely
    chk(outs() == PAT_FREE, "R12", outs(), PAT_FREE);
    for (int k = 1; k < d; k++) begin
      @(negedge clk); set_nop();
    end
    @(negedge clk); set_nop();
    id_rs1 = r1; id_rs1_used = u1; id_rs2 = r2; id_rs2_used = u2;
    st = 0; done = 1'b0; shape_ok = 1'b1;
    while (!done) begin
      #2;
      if (if_en || st > 5) begin
        done = 1'b1;
      end else begin
        st++;
        if (outs() != PAT_STALL) shape_ok = 1'b0;
        @(negedge clk);
      end
    end
    chk(st == exp_st, req, st, exp_st);
    if (st > 0) chk(shape_ok, "R2", 0, 1);
  endtask

  initial begin
    checks = 0; failures = 0;
    set_nop();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    // R1: free-running pattern after reset
    chk(outs() == PAT_FREE, "R1", outs(), PAT_FREE);

    // Sweep: writer index, write flag, distance, operand match and use flags
    for (int wi = 0; wi < 4; wi++) begin
      for (int we = 0; we < 2; we++) begin
        for (int d = 1; d <= 4; d++) begin
          for (int m1 = 0; m1 < 2; m1++) begin
            for (int u1 = 0; u1 < 2; u1++) begin
              for (int m2 = 0; m2 < 2; m2++) begin
                for (int u2 = 0; u2 < 2; u2++) begin
                  logic [AW-1:0] wr;
                  logic [AW-1:0] oth;
                  wr  = (wi == 0) ? 5'd0 : (wi == 1) ? 5'd1 : (wi == 2) ? 5'd7 : 5'd31;
                  oth = wr + 5'd3;
                  run_pair(wr, we[0], d, m1 ? wr : oth, u1[0], m2 ? wr : oth, u2[0]);
                end
              end
            end
          end
        end
      end
    end

    // R9: plain redirect with nothing in flight
    drain();
    @(negedge clk); set_nop(); mem_redirect = 1'b1;
    #2;
    chk(outs() == PAT_FLUSH, "R9", outs(), PAT_FLUSH);

    // R10 / R11: dependent reader in decode as the branch resolves
    drain();
    @(negedge clk); set_nop(); id_rd = 5'd9; id_rd_we = 1'b1;
    @(negedge clk); set_nop(); id_rs1 = 5'd9; id_rs1_used = 1'b1; mem_redirect = 1'b1;
    #2;
    chk(outs() == PAT_FLUSH, "R10", outs(), PAT_FLUSH);
    @(negedge clk); mem_redirect = 1'b0;
    #2;
    chk(outs() == PAT_FREE, "R11", outs(), PAT_FREE);

    // R11: writer itself in decode when the flush hits is squashed
    drain();
    @(negedge clk); set_nop(); id_rd = 5'd12; id_rd_we = 1'b1; mem_redirect = 1'b1;
    @(negedge clk); set_nop(); id_rs2 = 5'd12; id_rs2_used = 1'b1;
    #2;
    chk(outs() == PAT_FREE, "R11", outs(), PAT_FREE);

    // R10: flush in the middle of a two-cycle stall
    drain();
    @(negedge clk); set_nop(); id_rd = 5'd4; id_rd_we = 1'b1;
    @(negedge clk); set_nop(); id_rs1 = 5'd4; id_rs1_used = 1'b1;
    #2;
    chk(outs() == PAT_STALL, "R2", outs(), PAT_STALL);
    @(negedge clk); mem_redirect = 1'b1;
    #2;
    chk(outs() == PAT_FLUSH, "R10", outs(), PAT_FLUSH);
    @(negedge clk); mem_redirect = 1'b0;
    #2;
    chk(outs() == PAT_FREE, "R11", outs(), PAT_FREE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule